// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a core's store path and the system bus for address ranges that software has marked as write-combining. Each store carries one 8-byte-aligned chunk of data and a byte-enable mask. Stores are not forwarded right away. They are merged into a single line buffer that covers one 32-byte-aligned region and keeps a valid bit for every byte. A later store to a byte that is already valid replaces the held value, so only the most recent value reaches memory. The buffer is not snooped and makes no promise about the order in which bytes arrive at memory.

The buffer drains in four cases:
- a store targets a different region;
- every byte of the line is valid;
- a flush is requested;
- the buffer has gone a fixed number of cycles without a new store.

A fully valid line leaves as one burst write. Otherwise the buffer sends one write for each 8-byte chunk that holds valid bytes, and each of those writes carries that chunk's byte mask. The flush handshake lets software wait until every buffered byte has been accepted by the bus. This is the point at which it is safe to start a command buffer or show a frame.

Top module: `wcb_top`

## Requirements
- R1: While and right after reset, `st_ready` is 1, `bus_valid` is 0 and `flush_done` is 0, and the buffer holds no valid bytes.
- R2: A store accepted into an empty buffer, or into a buffer already holding its region, is held without any bus write. `bus_valid` stays 0 until a drain cause occurs.
- R3: When several accepted stores write the same byte, the value sent on the bus is the one from the last store. Bytes whose enable bit is 0 keep their earlier value and validity.
- R4: When an accepted store makes all 32 bytes valid, the next cycle shows a single write with `bus_burst`=1, the line-aligned address, `bus_be` all ones and the whole line on `bus_data`.
- R5: A drain of a line that is not full issues one write per 8-byte chunk holding any valid byte, lowest chunk first, with `bus_burst`=0. Each such write has address = line base + 8 × chunk index (address bits [4:3] give the chunk), data in `bus_data[63:0]` and the chunk's byte mask in `bus_be[7:0]`, and `bus_be[31:8]` is 0.
- R6: A store whose address bits above bit 4 differ from the held region, while the buffer holds valid bytes, sees `st_ready`=0. The held line then drains, and the store is accepted into the emptied buffer afterwards.
- R7: If 64 consecutive idle cycles pass with valid bytes held and no store accepted, the buffer drains. The first bus write appears 65 cycles after the cycle of the last accepted store.
- R8: A flush request seen while idle leads to a one-cycle `flush_done` pulse. The pulse comes in the cycle after the last drain write is accepted, or in the next cycle if the buffer is empty. A request that is still high during that pulse is not taken as a new request.
- R9: `st_ready` is 0 in every cycle in which a drain is in progress or a flush request is pending.
- R10: A bus write whose `bus_ready` is 0 stays presented, with unchanged address, byte enables and burst flag, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store byte address; bits [2:0] are ignored |
| st_data | input | 64 | Store data, byte k in bits [8k+7:8k] |
| st_be | input | 8 | Store byte enables |
| flush_req | input | 1 | Flush request, held until `flush_done` |
| flush_done | output | 1 | One-cycle flush completion pulse |
| bus_valid | output | 1 | Bus write request valid |
| bus_ready | input | 1 | Bus accepts the presented write |
| bus_addr | output | ADDR_W | Bus write address |
| bus_data | output | 256 | Bus write data (chunk writes use bits [63:0]) |
| bus_be | output | 32 | Bus byte enables |
| bus_burst | output | 1 | 1 for a full-line burst, 0 for a chunk write |

## Verification
Stores that fill four chunks of one line in order must give a single burst, while scattered partial stores must give ascending chunk writes. Comparing the two shows whether the full-line test and the chunk selection are separate. Repeated writes to one byte and disjoint byte masks in one chunk show whether bytes collapse or merge. A store to a new region, a quiet period and an explicit flush on an empty and on a full buffer each start a drain for a different reason, and each has its own timing for `st_ready` and `flush_done`. A final mixed run with random stores, random region changes and random `bus_ready` stall patterns is compared against the behavioural model in every cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic {
    WCB_IDLE  = 1'b0,
    WCB_DRAIN = 1'b1
  } wcb_state_e;
endpackage

// File: rtl/wcb_line_store.sv
// Byte-granular line storage: one valid flag and one data byte per lane.
module wcb_line_store #(
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(LINE_BYTES/CHUNK_BYTES)-1:0] wr_chunk,
  input  logic [CHUNK_BYTES*8-1:0]    wr_data,
  input  logic [CHUNK_BYTES-1:0]      wr_be,
  input  logic                        clr_all,
  input  logic                        clr_en,
  input  logic [$clog2(LINE_BYTES/CHUNK_BYTES)-1:0] clr_chunk,
  output logic [LINE_BYTES*8-1:0]     line_data,
  output logic [LINE_BYTES-1:0]       line_vld
);
  localparam int N_CHUNKS = LINE_BYTES / CHUNK_BYTES;
  localparam int CIDX_W   = $clog2(N_CHUNKS);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    localparam int                LANE_CHUNK = b / CHUNK_BYTES;
    localparam int                LANE_OFF   = b % CHUNK_BYTES;
    localparam logic [CIDX_W-1:0] LANE_IDX   = CIDX_W'(LANE_CHUNK);

    logic hit_wr;
    logic hit_clr;
    assign hit_wr  = wr_en && (wr_chunk == LANE_IDX) && wr_be[LANE_OFF];
    assign hit_clr = clr_all || (clr_en && (clr_chunk == LANE_IDX));

    always_ff @(posedge clk) begin
      if (rst) begin
        line_vld[b] <= 1'b0;
      end else if (hit_clr) begin
        line_vld[b] <= 1'b0;
      end else if (hit_wr) begin
        line_vld[b] <= 1'b1;
      end
    end

    // Data lanes carry no reset so they map onto plain enabled storage.
    always_ff @(posedge clk) begin
      if (hit_wr) begin
        line_data[b*8 +: 8] <= wr_data[LANE_OFF*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/wcb_chunk_pick.sv
// Finds occupied chunks, the lowest occupied chunk and full/empty status.
module wcb_chunk_pick #(
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 8
) (
  input  logic [LINE_BYTES*8-1:0]                   line_data,
  input  logic [LINE_BYTES-1:0]                     line_vld,
  output logic [LINE_BYTES/CHUNK_BYTES-1:0]         chunk_any,
  output logic [$clog2(LINE_BYTES/CHUNK_BYTES)-1:0] sel_idx,
  output logic [CHUNK_BYTES*8-1:0]                  sel_data,
  output logic [CHUNK_BYTES-1:0]                    sel_be,
  output logic                                      line_full,
  output logic                                      line_empty
);
  localparam int N_CHUNKS = LINE_BYTES / CHUNK_BYTES;
  localparam int CIDX_W   = $clog2(N_CHUNKS);
  localparam int CHUNK_W  = CHUNK_BYTES * 8;

  for (genvar c = 0; c < N_CHUNKS; c++) begin : g_chunk
    assign chunk_any[c] = |line_vld[c*CHUNK_BYTES +: CHUNK_BYTES];
  end

  always_comb begin
    sel_idx = '0;
    for (int i = N_CHUNKS - 1; i >= 0; i--) begin
      if (chunk_any[i]) sel_idx = CIDX_W'(i);
    end
  end

  assign sel_data   = line_data[int'(sel_idx)*CHUNK_W +: CHUNK_W];
  assign sel_be     = line_vld[int'(sel_idx)*CHUNK_BYTES +: CHUNK_BYTES];
  assign line_full  = &line_vld;
  assign line_empty = ~|line_vld;
endmodule

// File: rtl/wcb_idle_timer.sv
// Counts quiet cycles; expire is high on the last counted cycle.
module wcb_idle_timer #(
  parameter int IDLE_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (IDLE_LIMIT > 1) ? $clog2(IDLE_LIMIT) : 1;

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == CNT_W'(IDLE_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= expire ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wcb_top.sv
module wcb_top
  import wcb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 8,
  parameter int IDLE_LIMIT  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     st_valid,
  output logic                     st_ready,
  input  logic [ADDR_W-1:0]        st_addr,
  input  logic [CHUNK_BYTES*8-1:0] st_data,
  input  logic [CHUNK_BYTES-1:0]   st_be,
  input  logic                     flush_req,
  output logic                     flush_done,
  output logic                     bus_valid,
  input  logic                     bus_ready,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [LINE_BYTES*8-1:0]  bus_data,
  output logic [LINE_BYTES-1:0]    bus_be,
  output logic                     bus_burst
);
  localparam int LINE_W    = LINE_BYTES * 8;
  localparam int N_CHUNKS  = LINE_BYTES / CHUNK_BYTES;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int CHUNK_OFF = $clog2(CHUNK_BYTES);
  localparam int CIDX_W    = $clog2(N_CHUNKS);
  localparam int REG_W     = ADDR_W - OFF_W;

  wcb_state_e          state_q;
  logic [REG_W-1:0]    region_q;
  logic                fl_pend_q;
  logic                done_q;

  logic [REG_W-1:0]    st_region;
  logic [CIDX_W-1:0]   st_chunk;
  logic                unused_addr_lsb;
  logic                is_idle, region_hit, miss, flush_live, flush_take, accept;
  logic [LINE_BYTES-1:0] wr_mask;
  logic                full_next;

  logic [LINE_W-1:0]     line_data;
  logic [LINE_BYTES-1:0] line_vld;
  logic [N_CHUNKS-1:0]   chunk_any, chunk_rest;
  logic [CIDX_W-1:0]     sel_idx;
  logic [CHUNK_BYTES*8-1:0] sel_data;
  logic [CHUNK_BYTES-1:0]   sel_be;
  logic                line_full, line_empty;
  logic                bus_take, drain_last, timer_run, timer_expire;

  assign st_region       = st_addr[ADDR_W-1:OFF_W];
  assign st_chunk        = st_addr[OFF_W-1:CHUNK_OFF];
  assign unused_addr_lsb = ^st_addr[CHUNK_OFF-1:0];

  assign is_idle    = (state_q == WCB_IDLE);
  assign region_hit = (st_region == region_q);
  assign miss       = is_idle && st_valid && !line_empty && !region_hit;
  assign flush_live = flush_req && !done_q;
  assign flush_take = is_idle && flush_live;
  assign st_ready   = is_idle && !flush_live && !miss;
  assign accept     = st_valid && st_ready;

  assign wr_mask   = LINE_BYTES'(st_be) << {st_chunk, CHUNK_OFF'(0)};
  assign full_next = &(line_vld | wr_mask);

  wcb_line_store #(
    .LINE_BYTES (LINE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES)
  ) store_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept),
    .wr_chunk (st_chunk),
    .wr_data  (st_data),
    .wr_be    (st_be),
    .clr_all  (bus_take && line_full),
    .clr_en   (bus_take),
    .clr_chunk(sel_idx),
    .line_data(line_data),
    .line_vld (line_vld)
  );

  wcb_chunk_pick #(
    .LINE_BYTES (LINE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES)
  ) pick_i (
    .line_data (line_data),
    .line_vld  (line_vld),
    .chunk_any (chunk_any),
    .sel_idx   (sel_idx),
    .sel_data  (sel_data),
    .sel_be    (sel_be),
    .line_full (line_full),
    .line_empty(line_empty)
  );

  assign timer_run = is_idle && !line_empty && !accept && !flush_take && !miss;

  wcb_idle_timer #(
    .IDLE_LIMIT(IDLE_LIMIT)
  ) timer_i (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (timer_run),
    .expire(timer_expire)
  );

  // Bus side: every field is a function of registered state only.
  assign bus_valid  = !is_idle;
  assign bus_burst  = line_full;
  assign bus_addr   = line_full ? {region_q, OFF_W'(0)}
                                : {region_q, sel_idx, CHUNK_OFF'(0)};
  assign bus_data   = line_full ? line_data : LINE_W'(sel_data);
  assign bus_be     = line_full ? {LINE_BYTES{1'b1}} : LINE_BYTES'(sel_be);
  assign bus_take   = bus_valid && bus_ready;
  assign chunk_rest = chunk_any & ~(N_CHUNKS'(1) << sel_idx);
  assign drain_last = bus_take && (line_full || (chunk_rest == '0));
  assign flush_done = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= WCB_IDLE;
      region_q  <= '0;
      fl_pend_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WCB_IDLE: begin
          if (flush_take) begin
            if (line_empty) begin
              done_q <= 1'b1;
            end else begin
              state_q   <= WCB_DRAIN;
              fl_pend_q <= 1'b1;
            end
          end else if (miss) begin
            state_q <= WCB_DRAIN;
          end else if (accept) begin
            region_q <= st_region;
            if (full_next) state_q <= WCB_DRAIN;
          end else if (timer_expire) begin
            state_q <= WCB_DRAIN;
          end
        end
        WCB_DRAIN: begin
          if (drain_last) begin
            state_q   <= WCB_IDLE;
            done_q    <= fl_pend_q;
            fl_pend_q <= 1'b0;
          end
        end
        default: state_q <= WCB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 32,
  parameter int CHUNK_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    st_ready,
  input logic                    flush_req,
  input logic                    flush_done,
  input logic                    bus_valid,
  input logic                    bus_ready,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [LINE_BYTES-1:0]   bus_be,
  input logic                    bus_burst
);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int CHUNK_OFF = $clog2(CHUNK_BYTES);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_burst));

  p_drain_stall_r9: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !st_ready);

  p_flush_stall_r9: assert property (@(posedge clk) disable iff (rst)
    flush_req && !flush_done |-> !st_ready);

  p_burst_shape_r4: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_burst |-> (&bus_be) && (bus_addr[OFF_W-1:0] == '0));

  p_chunk_shape_r5: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_burst |-> (bus_be[LINE_BYTES-1:CHUNK_BYTES] == '0)
      && (|bus_be[CHUNK_BYTES-1:0]) && (bus_addr[CHUNK_OFF-1:0] == '0));
endmodule

bind wcb_top wcb_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .CHUNK_BYTES(CHUNK_BYTES)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .st_ready  (st_ready),
  .flush_req (flush_req),
  .flush_done(flush_done),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_burst (bus_burst)
);

// File: tb/wcb_top_tb_top.sv
`timescale 1ns/1ps
module wcb_top_tb_top;
  localparam int AW = 32;
  localparam int LB = 32;
  localparam int CB = 8;
  localparam int IL = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst;
  logic           st_valid;
  logic           st_ready;
  logic [AW-1:0]  st_addr;
  logic [63:0]    st_data;
  logic [CB-1:0]  st_be;
  logic           flush_req;
  logic           flush_done;
  logic           bus_valid;
  logic           bus_ready;
  logic [AW-1:0]  bus_addr;
  logic [255:0]   bus_data;
  logic [LB-1:0]  bus_be;
  logic           bus_burst;

  wcb_top dut_i (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .flush_req(flush_req), .flush_done(flush_done),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_be(bus_be), .bus_burst(bus_burst)
  );

  int vectors = 0;
  int miscompares = 0;

  // Behavioural reference state
  bit          m_drain, m_fpend, m_done;
  bit          m_vld[LB];
  logic [7:0]  m_dat[LB];
  longint      m_reg;
  int          m_quiet;
  bit          br_rand;
  bit          last_acc, obs_bv, obs_done;

  logic [AW-1:0]  cap_addr[$];
  logic [255:0]   cap_data[$];
  logic [LB-1:0]  cap_be[$];
  bit             cap_burst[$];

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // One clock: compare against the model, advance the model, move to next negedge.
  task automatic tick();
    bit emp, ful, exp_ready, nd;
    int lo;
    longint sreg;
    int sch;
    logic [AW-1:0] e_addr;
    logic [LB-1:0] e_be;
    #1;
    emp = 1; ful = 1; lo = 0;
    for (int b = 0; b < LB; b++) if (m_vld[b]) emp = 0; else ful = 0;
    for (int c = LB/CB - 1; c >= 0; c--) begin
      for (int k = 0; k < CB; k++) if (m_vld[c*CB+k]) lo = c;
    end
    sreg = longint'(st_addr >> 5);
    sch  = int'(st_addr[4:3]);
    exp_ready = !m_drain && !(flush_req && !m_done) && !(st_valid && !emp && sreg != m_reg);
    check(st_ready === exp_ready, "R9 st_ready", 256'(st_ready), 256'(exp_ready));
    check(bus_valid === m_drain, "R2 bus_valid", 256'(bus_valid), 256'(m_drain));
    check(flush_done === m_done, "R8 flush_done", 256'(flush_done), 256'(m_done));
    if (m_drain && bus_valid) begin
      check(bus_burst === ful, "R4 bus_burst", 256'(bus_burst), 256'(ful));
      e_be = '0;
      if (ful) begin
        e_addr = AW'(m_reg << 5);
        e_be   = '1;
      end else begin
        e_addr = AW'((m_reg << 5) + lo*8);
        for (int k = 0; k < CB; k++) e_be[k] = m_vld[lo*CB+k];
      end
      check(bus_addr === e_addr, "R5 bus_addr", 256'(bus_addr), 256'(e_addr));
      check(bus_be === e_be, "R5 bus_be", 256'(bus_be), 256'(e_be));
      for (int b = 0; b < LB; b++) begin
        if (e_be[b]) begin
          logic [7:0] eb;
          eb = ful ? m_dat[b] : m_dat[lo*CB + b];
          if (bus_data[b*8 +: 8] !== eb) check(0, "R3 bus_data byte", 256'(bus_data[b*8 +: 8]), 256'(eb));
        end
      end
    end
    if (bus_valid && bus_ready) begin
      cap_addr.push_back(bus_addr); cap_data.push_back(bus_data);
      cap_be.push_back(bus_be);     cap_burst.push_back(bus_burst);
    end
    obs_bv = bus_valid; obs_done = flush_done;
    last_acc = st_valid && exp_ready;
    // advance model
    nd = 0;
    if (!m_drain) begin
      if (flush_req && !m_done) begin
        if (emp) nd = 1; else begin m_drain = 1; m_fpend = 1; end
      end else if (st_valid && !emp && sreg != m_reg) begin
        m_drain = 1;
      end else if (st_valid) begin
        bit now_full;
        for (int k = 0; k < CB; k++) if (st_be[k]) begin
          m_vld[sch*CB+k] = 1; m_dat[sch*CB+k] = st_data[k*8 +: 8];
        end
        m_reg = sreg; m_quiet = 0;
        now_full = 1;
        for (int b = 0; b < LB; b++) if (!m_vld[b]) now_full = 0;
        if (now_full) m_drain = 1;
      end else if (!emp) begin
        m_quiet++;
        if (m_quiet == IL) m_drain = 1;
      end
    end else if (bus_ready) begin
      bit left;
      if (ful) for (int b = 0; b < LB; b++) m_vld[b] = 0;
      else     for (int k = 0; k < CB; k++) m_vld[lo*CB+k] = 0;
      left = 0;
      for (int b = 0; b < LB; b++) if (m_vld[b]) left = 1;
      if (!left) begin m_drain = 0; nd = m_fpend; m_fpend = 0; end
    end
    m_done = nd;
    @(negedge clk);
    if (br_rand) bus_ready = ($urandom_range(0, 3) != 0);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    do tick(); while (!last_acc);
    st_valid = 0;
  endtask

  task automatic do_flush();
    flush_req = 1;
    do tick(); while (!obs_done);
    flush_req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    int n, base;
    logic [AW-1:0] a0;
    rst = 1; st_valid = 0; st_addr = '0; st_data = '0; st_be = '0;
    flush_req = 0; bus_ready = 1; br_rand = 0;
    m_drain = 0; m_fpend = 0; m_done = 0; m_reg = 0; m_quiet = 0;
    for (int b = 0; b < LB; b++) begin m_vld[b] = 0; m_dat[b] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(st_ready === 1'b1, "R1 reset st_ready", 256'(st_ready), 256'(1));
    check(bus_valid === 1'b0, "R1 reset bus_valid", 256'(bus_valid), 256'(0));
    check(flush_done === 1'b0, "R1 reset flush_done", 256'(flush_done), 256'(0));
    rst = 0;

    // R4: four full chunks in order make one burst
    for (int c = 0; c < 4; c++) do_store(AW'(32'h1000 + c*8), {8{8'(8'hA0 + c)}}, 8'hFF);
    idle(3);
    check(cap_burst.size() == 1 && cap_burst[0] == 1, "R4 single burst", 256'(cap_burst.size()), 256'(1));
    check(cap_addr[0] == 32'h1000, "R4 burst addr", 256'(cap_addr[0]), 256'(32'h1000));
    check(cap_data[0][255:248] == 8'hA3 && cap_data[0][7:0] == 8'hA0, "R4 burst data",
          256'(cap_data[0]), 256'(0));
    cap_addr.delete(); cap_data.delete(); cap_be.delete(); cap_burst.delete();

    // R2/R5: scattered partial stores held, then flushed as ascending chunks
    do_store(32'h2010, 64'h0000_0000_4433_2211, 8'h0F);
    do_store(32'h2000, 64'h8877_6655_0000_0000, 8'hF0);
    idle(5);
    check(obs_bv == 0 && cap_addr.size() == 0, "R2 held without bus write", 256'(cap_addr.size()), 256'(0));
    do_flush();
    check(cap_addr.size() == 2, "R5 two chunk writes", 256'(cap_addr.size()), 256'(2));
    check(cap_addr[0] == 32'h2000 && cap_be[0] == 32'hF0, "R5 first chunk", 256'(cap_addr[0]), 256'(32'h2000));
    check(cap_addr[1] == 32'h2010 && cap_be[1] == 32'h0F, "R5 second chunk", 256'(cap_addr[1]), 256'(32'h2010));
    check(cap_burst[0] == 0, "R5 burst flag low", 256'(cap_burst[0]), 256'(0));
    cap_addr.delete(); cap_data.delete(); cap_be.delete(); cap_burst.delete();

    // R3: same byte twice, neighbour byte once
    do_store(32'h3008, 64'h11, 8'h01);
    do_store(32'h3008, 64'h22, 8'h01);
    do_store(32'h3008, 64'h3300, 8'h02);
    do_flush();
    check(cap_data[0][15:0] == 16'h3322 && cap_be[0] == 32'h3, "R3 last value wins",
          256'(cap_data[0][15:0]), 256'(16'h3322));
    cap_addr.delete(); cap_data.delete(); cap_be.delete(); cap_burst.delete();

    // R6: region change evicts before accepting
    do_store(32'h4000, 64'h0102030405060708, 8'hFF);
    st_valid = 1; st_addr = 32'h4020; st_data = 64'h55; st_be = 8'h01;
    tick();
    check(last_acc == 0, "R6 store to new region stalled", 256'(last_acc), 256'(0));
    while (!last_acc) tick();
    st_valid = 0;
    check(cap_addr.size() == 1 && cap_addr[0] == 32'h4000, "R6 old line drained first",
          256'(cap_addr.size()), 256'(1));
    do_flush();
    check(cap_addr[1] == 32'h4020, "R6 new store kept", 256'(cap_addr[1]), 256'(32'h4020));
    cap_addr.delete(); cap_data.delete(); cap_be.delete(); cap_burst.delete();

    // R7: timeout drain
    do_store(32'h5000, 64'h7, 8'h01);
    n = 0;
    do begin tick(); n++; end while (!obs_bv && n < 100);
    check(n == 65, "R7 timeout latency", 256'(n), 256'(65));
    idle(2);

    // R8: flush on empty buffer answers next cycle
    flush_req = 1;
    tick();
    check(obs_done == 0, "R8 empty flush not same cycle", 256'(obs_done), 256'(0));
    tick();
    check(obs_done == 1, "R8 empty flush done next cycle", 256'(obs_done), 256'(1));
    flush_req = 0;
    tick();
    check(obs_done == 0, "R8 single pulse", 256'(obs_done), 256'(0));

    // R10: stalled bus keeps the write stable
    do_store(32'h6008, 64'hAB, 8'h01);
    do_store(32'h6018, 64'hCD, 8'h01);
    bus_ready = 0; flush_req = 1;
    tick(); tick();
    a0 = bus_addr;
    idle(4);
    check(bus_valid === 1'b1 && bus_addr === a0, "R10 held while stalled", 256'(bus_addr), 256'(a0));
    bus_ready = 1;
    while (!obs_done) tick();
    flush_req = 0;
    tick();

    // Mixed random traffic with random back-pressure
    br_rand = 1;
    for (int i = 0; i < 600; i++) begin
      base = 32'h7000 + 32 * $urandom_range(0, 2);
      if ($urandom_range(0, 19) == 0) do_flush();
      else if ($urandom_range(0, 29) == 0) idle(70);
      else do_store(AW'(base + 8 * $urandom_range(0, 3)), {$urandom, $urandom},
                    8'($urandom_range(0, 255)));
    end
    do_flush();
    br_rand = 0; bus_ready = 1;
    idle(3);

    summary();
    $finish;
  end
endmodule